// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block turns three fan tachometer pulse trains into three 8-bit speed readings in the usual hardware-monitor form. A fast fan gives a small number and a slow fan gives a large one. For each fan it counts ticks of a 22.5 kHz reference over one revolution. The reference comes from the system clock through a prescaler. A revolution is two tach pulses, so a window spans three rising edges. The tick count is divided by a per-fan divisor, 2^code. The reading is `1 350 000 / (rpm × divisor)`, held between 1 and 255.

The divisor codes arrive as configuration bytes from a register file outside this block. Each fan's two low code bits sit in a fixed field of one of two bytes. When the extended-divisor parameter is set, a third code bit for each fan comes from a separate byte, which allows divisors up to 128. A fan that stops, or that turns too slowly to finish a revolution within 255 × divisor ticks, reads 255.

Each fan has a three-state machine. `MS_IDLE` waits for an edge that opens a window. `MS_FIRST_HALF` counts until the middle edge. `MS_SECOND_HALF` counts until the closing edge. These are the transitions:
- IDLE→FIRST_HALF on a rising edge. This latches the divisor code and clears the counters.
- FIRST_HALF→SECOND_HALF on a rising edge.
- SECOND_HALF→FIRST_HALF on the closing rising edge. This loads the reading, pulses the update strobe, and opens the next window at once.
- FIRST_HALF→IDLE and SECOND_HALF→IDLE on overflow. This loads 255 and pulses the update strobe. In FIRST_HALF, overflow wins over a coincident edge.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every reading is 255 (0xFF) and every update strobe is low.
- R2: For each fan, let N be the number of reference ticks in the cycles after a window-opening rising edge, up to and including the closing rising edge two pulses later. The reading becomes floor(N / divisor). It is loaded in the same cycle as a one-cycle pulse on that fan's bit of `fan_upd`.
- R3: The divisor is 2^code. The code bits [1:0] come from `cfg_fan12_div` bits [5:4] for fan 0, from `cfg_fan12_div` bits [7:6] for fan 1, and from `cfg_fan3_div` bits [7:6] for fan 2.
- R4: With EXT_DIV_EN=1, code bit 2 comes from `cfg_div_ext` bit 4 for fan 0, bit 5 for fan 1 and bit 6 for fan 2. This gives divisors up to 128.
- R5: A reading that would be 0, because the fan is very fast, is loaded as 1. A reading is never 0.
- R6: If 255 × divisor reference ticks pass after a window opens without a closing edge, the reading is loaded with 255 and strobed. The meter then waits for a fresh rising edge before it opens a new window.
- R7: A revolution of 254 × divisor ticks reads 254. This is the largest value that is not saturated.
- R8: The closing edge of one window opens the next. A steady fan of K pulses (K odd) yields (K−1)/2 readings, followed by one 255 once it stops.
- R9: A reading changes only in a cycle in which its update strobe is high.
- R10: The reference tick is one system-clock cycle wide. It repeats every CLK_HZ/REF_HZ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | 3 | Raw tach inputs, one bit per fan |
| cfg_fan12_div | input | 8 | Configuration byte with the low divisor code bits for fans 0 and 1 |
| cfg_fan3_div | input | 8 | Configuration byte with the low divisor code bits for fan 2 |
| cfg_div_ext | input | 8 | Configuration byte with the extended code bit for each fan |
| fan_count_0 | output | 8 | Reading for fan 0 |
| fan_count_1 | output | 8 | Reading for fan 1 |
| fan_count_2 | output | 8 | Reading for fan 2 |
| fan_upd | output | 3 | One-cycle strobe per fan, high when that reading is loaded |

## Verification
The one-cycle strobe property assumes that tach rising edges reach the meter at least two cycles apart. The bench meets this by giving every pulse a high phase of one cycle and a pulse period of at least three cycles. The assertions also assume that the configuration bytes change only while the meters are idle. The bench therefore rewrites them only after every fan has stalled and its 255 reading has been consumed. Every pulse spacing is a whole number of cycles and the prescaler is even, so each revolution contains an exact, phase-independent number of ticks.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int NFANS      = 3;
    localparam int CNT_W      = 8;
    localparam int CODE_W     = 3;
    localparam int MAX_CODE   = (1 << CODE_W) - 1;
    localparam int SUB_W      = MAX_CODE;
    localparam logic [CNT_W-1:0] SAT_VAL   = '1;
    localparam logic [CNT_W-1:0] LAST_FREE = SAT_VAL - 8'd1;

    typedef enum logic [1:0] {
        MS_IDLE        = 2'd0,
        MS_FIRST_HALF  = 2'd1,
        MS_SECOND_HALF = 2'd2
    } meter_state_t;

    typedef logic [CODE_W-1:0] div_code_t;

    function automatic logic [CNT_W-1:0] floor_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
    endfunction

endpackage

// File: rtl/fan_ref_tick.sv
module fan_ref_tick #(
    parameter int PRESCALE = 8888
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_pass
            assign tick = rst_n;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] TOP = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt <= '0;
                end else if (pcnt == TOP) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign tick = (pcnt == TOP);
        end
    endgenerate
endmodule

// File: rtl/fan_tach_edge.sv
module fan_tach_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_raw,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q[0] <= tach_raw;
            last_q    <= sync_q[SYNC_STAGES-1];
        end
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[s] <= 1'b0;
                end else begin
                    sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/fan_div_select.sv
module fan_div_select
    import fan_tach_pkg::*;
#(
    parameter bit EXT_DIV_EN = 1'b1
) (
    input  logic [7:0]      cfg_fan12_div,
    input  logic [7:0]      cfg_fan3_div,
    input  logic [7:0]      cfg_div_ext,
    output div_code_t       code [NFANS]
);
    localparam int EXT_BASE = 4;

    logic [1:0] low_bits [NFANS];

    // Field placement of the low code bits is fixed per fan.
    assign low_bits[0] = cfg_fan12_div[5:4];
    assign low_bits[1] = cfg_fan12_div[7:6];
    assign low_bits[2] = cfg_fan3_div[7:6];

    generate
        for (genvar f = 0; f < NFANS; f++) begin : g_fan
            if (EXT_DIV_EN) begin : g_ext
                assign code[f] = {cfg_div_ext[EXT_BASE + f], low_bits[f]};
            end else begin : g_base
                assign code[f] = {1'b0, low_bits[f]};
            end
        end
    endgenerate
endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
    import fan_tach_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             rise,
    input  div_code_t        live_code,
    output logic [CNT_W-1:0] count,
    output logic             upd
);
    meter_state_t     state, state_nx;
    div_code_t        cur_code;
    logic [SUB_W-1:0] sub_q;
    logic [CNT_W-1:0] cnt_q;

    logic [SUB_W-1:0] div_m1;
    logic             carry;
    logic             overflow;
    logic             close_win;
    logic [CNT_W-1:0] close_val;

    assign div_m1    = (SUB_W'(1) << cur_code) - SUB_W'(1);
    assign carry     = ref_tick && (sub_q == div_m1);
    assign overflow  = carry && (cnt_q == LAST_FREE);
    assign close_val = cnt_q + CNT_W'(carry);
    assign close_win = (state == MS_SECOND_HALF) && rise;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE: begin
                if (rise) state_nx = MS_FIRST_HALF;
            end
            MS_FIRST_HALF: begin
                if (overflow)  state_nx = MS_IDLE;
                else if (rise) state_nx = MS_SECOND_HALF;
            end
            MS_SECOND_HALF: begin
                if (rise)          state_nx = MS_FIRST_HALF;
                else if (overflow) state_nx = MS_IDLE;
            end
            default: state_nx = MS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MS_IDLE;
        else        state <= state_nx;
    end

    // Counters, code latch and reading
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_code <= '0;
            sub_q    <= '0;
            cnt_q    <= '0;
            count    <= SAT_VAL;
            upd      <= 1'b0;
        end else begin
            upd <= 1'b0;
            unique case (state)
                MS_IDLE: begin
                    cur_code <= live_code;
                    sub_q    <= '0;
                    cnt_q    <= '0;
                end
                MS_FIRST_HALF, MS_SECOND_HALF: begin
                    if (close_win) begin
                        count    <= floor_one(close_val);
                        upd      <= 1'b1;
                        cur_code <= live_code;
                        sub_q    <= '0;
                        cnt_q    <= '0;
                    end else if (overflow) begin
                        count <= SAT_VAL;
                        upd   <= 1'b1;
                        sub_q <= '0;
                        cnt_q <= '0;
                    end else if (ref_tick) begin
                        if (carry) begin
                            sub_q <= '0;
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                end
                default: begin
                    sub_q <= '0;
                    cnt_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int REF_HZ      = 22_500,
    parameter bit EXT_DIV_EN  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFANS-1:0] tach_in,
    input  logic [7:0]       cfg_fan12_div,
    input  logic [7:0]       cfg_fan3_div,
    input  logic [7:0]       cfg_div_ext,
    output logic [7:0]       fan_count_0,
    output logic [7:0]       fan_count_1,
    output logic [7:0]       fan_count_2,
    output logic [NFANS-1:0] fan_upd
);
    localparam int PRESCALE = CLK_HZ / REF_HZ;

    logic             ref_tick;
    logic [NFANS-1:0] rise;
    div_code_t        code [NFANS];
    logic [CNT_W-1:0] counts [NFANS];

    fan_ref_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick)
    );

    fan_div_select #(.EXT_DIV_EN(EXT_DIV_EN)) u_div (
        .cfg_fan12_div (cfg_fan12_div),
        .cfg_fan3_div  (cfg_fan3_div),
        .cfg_div_ext   (cfg_div_ext),
        .code          (code)
    );

    generate
        for (genvar f = 0; f < NFANS; f++) begin : g_fan
            fan_tach_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .tach_raw (tach_in[f]),
                .rise     (rise[f])
            );
            fan_period_meter u_meter (
                .clk       (clk),
                .rst_n     (rst_n),
                .ref_tick  (ref_tick),
                .rise      (rise[f]),
                .live_code (code[f]),
                .count     (counts[f]),
                .upd       (fan_upd[f])
            );
        end
    endgenerate

    assign fan_count_0 = counts[0];
    assign fan_count_1 = counts[1];
    assign fan_count_2 = counts[2];
endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk #(
    parameter int PRESCALE = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic [2:0] fan_upd,
    input logic [7:0] fan_count_0,
    input logic [7:0] fan_count_1,
    input logic [7:0] fan_count_2
);
    logic [7:0] cnt_v [3];
    assign cnt_v[0] = fan_count_0;
    assign cnt_v[1] = fan_count_1;
    assign cnt_v[2] = fan_count_2;

    generate
        for (genvar f = 0; f < 3; f++) begin : g_fan
            AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_v[f] != 8'd0);                                   // R5
            AST_CHANGE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(cnt_v[f]) |-> fan_upd[f]);                  // R9
            AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                fan_upd[f] |=> !fan_upd[f]);                         // R2
        end
        if (PRESCALE > 1) begin : g_tick
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                ref_tick |=> !ref_tick);                             // R10
        end
    endgenerate
endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.PRESCALE(CLK_HZ / REF_HZ)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .fan_upd     (fan_upd),
    .fan_count_0 (fan_count_0),
    .fan_count_1 (fan_count_1),
    .fan_count_2 (fan_count_2)
);

// File: tb/fan_tach_monitor_tb_top.sv
module fan_tach_monitor_tb_top;
    localparam int P = 2; // reference prescale used by the bench

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       t0 = 1'b0, t1 = 1'b0, t2 = 1'b0;
    logic [7:0] cfg_a = 8'h50, cfg_b = 8'h40, cfg_e = 8'h00;
    logic [7:0] c0, c1, c2;
    logic [2:0] upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          expq0[$];
    int          expq1[$];
    int          expq2[$];

    always #2.5 clk = ~clk;

    fan_tach_monitor #(
        .CLK_HZ(200_000_000), .REF_HZ(100_000_000), .EXT_DIV_EN(1'b1), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tach_in({t2, t1, t0}),
        .cfg_fan12_div(cfg_a), .cfg_fan3_div(cfg_b), .cfg_div_ext(cfg_e),
        .fan_count_0(c0), .fan_count_1(c1), .fan_count_2(c2), .fan_upd(upd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int reading(input int ticks, input int div);
        int v;
        v = ticks / div;
        if (v > 255) v = 255;
        if (v < 1) v = 1;
        return v;
    endfunction

    task automatic push_exp(input int f, input int val, input int n);
        for (int i = 0; i < n; i++) begin
            if (f == 0) expq0.push_back(val);
            else if (f == 1) expq1.push_back(val);
            else expq2.push_back(val);
        end
    endtask

    task automatic set_tach(input int f, input logic v);
        if (f == 0) t0 = v;
        else if (f == 1) t1 = v;
        else t2 = v;
    endtask

    // Driver: k pulses, one cycle high, period q cycles (revolution = q ticks).
    task automatic run_fan(input int f, input int q, input int k);
        for (int p = 0; p < k; p++) begin
            @(negedge clk) set_tach(f, 1'b1);
            @(negedge clk) set_tach(f, 1'b0);
            repeat (q - 2) @(negedge clk);
        end
    endtask

    task automatic drain(input string tag, input int cycles);
        repeat (cycles) @(negedge clk);
        check({tag, " queue0 empty"}, expq0.size(), 0);
        check({tag, " queue1 empty"}, expq1.size(), 0);
        check({tag, " queue2 empty"}, expq2.size(), 0);
    endtask

    // Monitor: pop and compare on every update strobe.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (upd[0]) begin
                if (expq0.size() == 0) check("R2 fan0 unexpected update", c0, -1);
                else check("R2 fan0 reading", c0, expq0.pop_front());
            end
            if (upd[1]) begin
                if (expq1.size() == 0) check("R2 fan1 unexpected update", c1, -1);
                else check("R2 fan1 reading", c1, expq1.pop_front());
            end
            if (upd[2]) begin
                if (expq2.size() == 0) check("R2 fan2 unexpected update", c2, -1);
                else check("R2 fan2 reading", c2, expq2.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (190_000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 fan0 reset", c0, 255);
        check("R1 fan1 reset", c1, 255);
        check("R1 fan2 reset", c2, 255);
        check("R1 strobes low", upd, 0);

        // R2 R3 R8: default-style codes, divisor 2 everywhere
        cfg_a = 8'h50; cfg_b = 8'h40; cfg_e = 8'h00;
        push_exp(0, reading(100, 2), 2); push_exp(0, 255, 1);
        push_exp(1, reading(40, 2), 2);  push_exp(1, 255, 1);
        push_exp(2, reading(300, 2), 2); push_exp(2, 255, 1);
        fork
            run_fan(0, 100, 5);
            run_fan(1, 40, 5);
            run_fan(2, 300, 5);
        join
        drain("R8 div2", 255 * 2 * P + 200);

        // R3: fan0 code 0 (div1), fan1 code 3 (div8), fan2 code 2 (div4)
        cfg_a = 8'hC0; cfg_b = 8'h80;
        push_exp(0, reading(20, 1), 2);  push_exp(0, 255, 1);
        push_exp(1, reading(200, 8), 2); push_exp(1, 255, 1);
        push_exp(2, reading(50, 4), 2);  push_exp(2, 255, 1);
        fork
            run_fan(0, 20, 5);
            run_fan(1, 200, 5);
            run_fan(2, 50, 5);
        join
        drain("R3 mixed codes", 255 * 8 * P + 200);

        // R4: extended bit, fan0 code 7 (div128), fan1 code 4 (div16), fan2 code 6 (div64)
        cfg_a = 8'h30; cfg_b = 8'h80; cfg_e = 8'h70;
        push_exp(0, reading(1280, 128), 2); push_exp(0, 255, 1);
        push_exp(1, reading(160, 16), 2);   push_exp(1, 255, 1);
        push_exp(2, reading(640, 64), 2);   push_exp(2, 255, 1);
        fork
            run_fan(0, 1280, 5);
            run_fan(1, 160, 5);
            run_fan(2, 640, 5);
        join
        drain("R4 extended", 255 * 128 * P + 200);

        // R7 (254 at div1), R5 (fast fan clamps to 1 at div8), R6 (slow fan div1 saturates)
        cfg_a = 8'hC0; cfg_b = 8'h00; cfg_e = 8'h00;
        push_exp(0, 254, 1);             push_exp(0, 255, 1);   // R7
        push_exp(1, reading(3, 8), 2);   push_exp(1, 255, 1);   // R5
        push_exp(2, 255, 3);                                    // R6
        fork
            run_fan(0, 254, 3);
            run_fan(1, 3, 5);
            run_fan(2, 300, 5);
        join
        drain("R6 R7 R5 limits", 255 * 8 * P + 200);
        check("R5 fan1 final nonzero", (c1 != 0) ? 1 : 0, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule